// File: doc/BRIEF.md
# Scatter/Gather Channel Start Control Register

This block holds the per-channel start bits that launch and halt scatter/gather sequences in a four-channel DMA engine. Software reaches it through a 32-bit word bus with two word selects: the command word and the error status word. In the command word, every channel's start bit is paired with an enable-mask bit. A write changes a start bit only when its mask bit is one in that same write. Because of this, software can start or stop one channel without a read-modify-write and without disturbing the other channels.

The transfer engine drives three signals per channel: a sequence-complete pulse, a descriptor-fetch failure pulse and a busy level. Either pulse clears the channel's start bit. A fetch failure also latches a sticky error flag, and software clears that flag by writing one to it. Each channel has a run output that follows its start bit. It also has a stop-pending output, which tells the engine that software asked for a halt while a transfer was still in flight. That transfer is allowed to finish.

Top module: `sg_cmd_reg`

## Requirements
- R1: After reset, all run, stop-pending and error outputs are zero, and reads of both words return zero.
- R2: With `addr_i`=0, a write loads start bit n from `wdata_i[31-n]` only when mask bit `wdata_i[15-n]` is 1. Otherwise start bit n keeps its value.
- R3: A read with `addr_i`=0 returns start bit n on `rdata_o[31-n]`. All other bits, including the mask bits, read as zero.
- R4: `run_o[n]` equals start bit n. It changes on the clock edge that ends the write.
- R5: A pulse on `seq_done_i[n]` clears start bit n on the next edge.
- R6: A pulse on `fetch_err_i[n]` clears start bit n and sets error flag n. The flag is visible on `err_o[n]` and on `rdata_o[31-n]` with `addr_i`=1.
- R7: When a hardware clear and an enabled software write hit the same start bit in one cycle, the bit ends up 0.
- R8: `stop_pend_o[n]` sets when an enabled write turns a set start bit to 0 while `xfer_busy_i[n]` is 1. It stays set while busy stays 1, and it is 0 on the edge after a cycle with busy at 0.
- R9: A write with `addr_i`=1 clears error flag n when `wdata_i[31-n]` is 1. A same-cycle fetch failure on that channel keeps the flag set.
- R10: A write to the error word leaves the start bits unchanged. A write to the command word leaves the error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 1 | Word select: 0 command, 1 error status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected word |
| seq_done_i | input | 4 | Per-channel sequence-complete pulse |
| fetch_err_i | input | 4 | Per-channel descriptor-fetch failure pulse |
| xfer_busy_i | input | 4 | Per-channel transfer-in-flight level |
| run_o | output | 4 | Per-channel run enable |
| stop_pend_o | output | 4 | Per-channel halt requested during a transfer |
| err_o | output | 4 | Per-channel sticky fetch-error flag |

## Verification
The start bit is the only state that decides whether a channel runs. A wrong start bit therefore shows on `run_o` and in the command readback on the edge right after the write or pulse that caused it, and it stays wrong until another write or a hardware clear overwrites it. A wrong stop-pending or error flag also shows one edge after its cause. The checks that target collisions, where a hardware clear or error set arrives in the same cycle as a software write, are the ones that tell a wrong priority apart from correct behaviour.

// File: rtl/sg_cmd_pkg.sv
package sg_cmd_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;

  typedef enum logic {
    SEL_CMD = 1'b0,
    SEL_ERR = 1'b1
  } word_sel_e;

  // MSB-first numbering: channel n lives at bit (width-1-n)
  function automatic int unsigned start_pos(int unsigned ch);
    return DATA_W - 1 - ch;
  endfunction

  function automatic int unsigned mask_pos(int unsigned ch);
    return HALF_W - 1 - ch;
  endfunction
endpackage

// File: rtl/sg_chan_ctrl.sv
module sg_chan_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_we_i,
  input  logic sw_val_i,
  input  logic seq_done_i,
  input  logic fetch_err_i,
  input  logic xfer_busy_i,
  output logic run_o,
  output logic stop_pend_o
);
  logic start_q, pend_q, hw_clr, sw_stop;

  assign hw_clr  = seq_done_i | fetch_err_i;
  assign sw_stop = sw_we_i & ~sw_val_i & start_q & ~hw_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (hw_clr)       start_q <= 1'b0;
      else if (sw_we_i) start_q <= sw_val_i;
      pend_q <= xfer_busy_i & (pend_q | sw_stop);
    end
  end

  assign run_o       = start_q;
  assign stop_pend_o = pend_q;

  // R7
  hw_clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_done_i || fetch_err_i) |=> !run_o);

  // R2
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_we_i && !seq_done_i && !fetch_err_i) |=> $stable(run_o));

  // R8
  pend_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_busy_i |=> !stop_pend_o);
endmodule

// File: rtl/sg_err_status.sv
module sg_err_status #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] err_o
);
  logic [NCH-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (err_q & ~clr_i) | set_i;
  end

  assign err_o = err_q;

  // R6
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((err_o & $past(set_i)) == $past(set_i)));

  // R9
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((err_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/sg_cmd_reg.sv
module sg_cmd_reg
  import sg_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] seq_done_i,
  input  logic [NUM_CH-1:0] fetch_err_i,
  input  logic [NUM_CH-1:0] xfer_busy_i,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] stop_pend_o,
  output logic [NUM_CH-1:0] err_o
);
  logic              cmd_we, err_we;
  logic [NUM_CH-1:0] err_clr;
  logic [DATA_W-1:0] cmd_word, err_word;
  logic              unused_wdata;

  assign cmd_we       = wr_en_i & (word_sel_e'(addr_i) == SEL_CMD);
  assign err_we       = wr_en_i & (word_sel_e'(addr_i) == SEL_ERR);
  assign unused_wdata = ^wdata_i;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int unsigned SP = start_pos(n);
    localparam int unsigned MP = mask_pos(n);

    sg_chan_ctrl u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sw_we_i     (cmd_we & wdata_i[MP]),
      .sw_val_i    (wdata_i[SP]),
      .seq_done_i  (seq_done_i[n]),
      .fetch_err_i (fetch_err_i[n]),
      .xfer_busy_i (xfer_busy_i[n]),
      .run_o       (run_o[n]),
      .stop_pend_o (stop_pend_o[n])
    );

    assign err_clr[n] = err_we & wdata_i[SP];
  end

  sg_err_status #(.NCH(NUM_CH)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fetch_err_i),
    .clr_i  (err_clr),
    .err_o  (err_o)
  );

  always_comb begin
    cmd_word = '0;
    err_word = '0;
    for (int unsigned n = 0; n < NUM_CH; n++) begin
      cmd_word[start_pos(n)] = run_o[n];
      err_word[start_pos(n)] = err_o[n];
    end
  end

  assign rdata_o = addr_i ? err_word : cmd_word;

  // R10
  err_word_isolation_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_we && seq_done_i == '0 && fetch_err_i == '0) |=> $stable(run_o));

  // R10
  cmd_word_isolation_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_we && fetch_err_i == '0) |=> $stable(err_o));
endmodule

// File: tb/sim_sg_cmd_reg.sv
module sim_sg_cmd_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  done = '0, ferr = '0, busy = '0;
  logic [3:0]  run, pend, err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sg_cmd_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .seq_done_i(done),
    .fetch_err_i(ferr), .xfer_busy_i(busy), .run_o(run),
    .stop_pend_o(pend), .err_o(err)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] wd;
    logic [3:0]  dn, fe, bz, e_run, e_pend, e_err;
  } vec_t;

  // command-word writes; start ch n at bit 31-n, mask ch n at bit 15-n
  localparam vec_t VECS [10] = '{
    '{1'b1, 32'hF000_F000, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0}, // R2 start all
    '{1'b1, 32'h0000_0000, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0}, // R2 no mask
    '{1'b1, 32'h0000_8000, 4'h0, 4'h0, 4'h1, 4'hE, 4'h1, 4'h0}, // R8 stop busy
    '{1'b0, 32'h0000_0000, 4'h0, 4'h0, 4'h1, 4'hE, 4'h1, 4'h0}, // R8 hold
    '{1'b0, 32'h0000_0000, 4'h0, 4'h0, 4'h0, 4'hE, 4'h0, 4'h0}, // R8 drop
    '{1'b0, 32'h0000_0000, 4'h2, 4'h0, 4'h0, 4'hC, 4'h0, 4'h0}, // R5
    '{1'b0, 32'h0000_0000, 4'h0, 4'h4, 4'h0, 4'h8, 4'h0, 4'h4}, // R6
    '{1'b1, 32'h1000_1000, 4'h8, 4'h0, 4'h0, 4'h0, 4'h0, 4'h4}, // R7
    '{1'b1, 32'h6000_6000, 4'h0, 4'h0, 4'h0, 4'h6, 4'h0, 4'h4}, // R4
    '{1'b1, 32'hFFFF_0FFF, 4'h0, 4'h0, 4'h0, 4'h6, 4'h0, 4'h4}  // R2 reserved only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic a, input logic [31:0] wd,
                       input logic [3:0] dn, input logic [3:0] fe, input logic [3:0] bz);
    @(negedge clk);
    wr_en = we; addr = a; wdata = wd; done = dn; ferr = fe; busy = bz;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    wr_en = 1'b0; addr = a; done = '0; ferr = '0; busy = '0;
    #1;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 run", {28'h0, run}, 32'h0);
    check("R1 pend", {28'h0, pend}, 32'h0);
    check("R1 err", {28'h0, err}, 32'h0);
    check("R1 rd cmd", rdata, 32'h0);
    addr = 1'b1; #1;
    check("R1 rd err", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    foreach (VECS[i]) begin
      cycle(VECS[i].we, 1'b0, VECS[i].wd, VECS[i].dn, VECS[i].fe, VECS[i].bz);
      check($sformatf("R2 R4 R5 R6 R7 R8 run v%0d", i), {28'h0, run}, {28'h0, VECS[i].e_run});
      check($sformatf("R8 pend v%0d", i), {28'h0, pend}, {28'h0, VECS[i].e_pend});
      check($sformatf("R6 err v%0d", i), {28'h0, err}, {28'h0, VECS[i].e_err});
    end

    rd(1'b0);
    check("R3 cmd readback", rdata, 32'h6000_0000);
    rd(1'b1);
    check("R6 err readback", rdata, 32'h2000_0000);

    // R9 clear other channels only, R10 starts untouched
    cycle(1'b1, 1'b1, 32'hD000_0000, 4'h0, 4'h0, 4'h0);
    check("R9 w1c others", {28'h0, err}, 32'h4);
    check("R10 run after err write", {28'h0, run}, 32'h6);

    // R9 set beats clear, R6 clears ch2 start
    cycle(1'b1, 1'b1, 32'h2000_0000, 4'h0, 4'h4, 4'h0);
    check("R9 set wins", {28'h0, err}, 32'h4);
    check("R6 start cleared", {28'h0, run}, 32'h2);

    cycle(1'b1, 1'b1, 32'h2000_0000, 4'h0, 4'h0, 4'h0);
    check("R9 w1c", {28'h0, err}, 32'h0);

    // R10 command write keeps error flags; stop idle channel gives no pending
    cycle(1'b1, 1'b1, 32'h0, 4'h0, 4'h1, 4'h0);
    cycle(1'b1, 1'b0, 32'h0000_F000, 4'h0, 4'h0, 4'h0);
    check("R10 err after cmd write", {28'h0, err}, 32'h1);
    check("R8 idle stop", {28'h0, pend}, 32'h0);
    check("R2 all stopped", {28'h0, run}, 32'h0);

    rd(1'b0);
    check("R3 cmd zero", rdata, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule